// File: doc/BRIEF.md
# Bit Shift and Rotate Unit

A purely combinational datapath slice for an 8-bit processor core. It carries out the shift, rotate and nibble-swap group, the single-bit test, and the single-bit clear and set operations. The operand comes from the core's register read path and the incoming carry comes from its flag register. The unit returns a result byte with a write enable and four new flag values, each with its own write mask. Fetching the operand and writing back the result and flags are left to the surrounding core.

A class select picks among four families: shift/rotate, bit test, bit clear and bit set. Inside the shift/rotate family, a 3-bit operation code picks one of eight operations. A separate input marks the short accumulator-only rotate forms. Those forms differ only in that they never report a zero result. There is no handshake: every output follows the inputs in the same cycle, and the core registers whatever it needs.

Top module: `bit_shift_rotate_unit`

## Requirements
- R1: With class 0, op 0 rotates left and copies bit 7 into both bit 0 and carry out. Op 1 rotates right and copies bit 0 into both bit 7 and carry out.
- R2: With class 0, op 2 rotates left through carry: the incoming carry enters bit 0 and bit 7 leaves as carry out. Op 3 rotates right through carry: the incoming carry enters bit 7 and bit 0 leaves as carry out.
- R3: With class 0, op 4 shifts left with zero fill, and bit 7 becomes carry out. Op 5 shifts right and keeps bit 7, with bit 0 as carry out. Op 7 shifts right with zero fill, with bit 0 as carry out.
- R4: With class 0, op 6 exchanges the upper and lower nibbles and drives carry out to 0.
- R5: For every class 0 operation, N and H are 0 and Z is 1 exactly when the result is zero. The result write enable is 1, and the flag mask is 4'b1111. Mask bit 3 is Z, bit 2 is N, bit 1 is H and bit 0 is C.
- R6: When the accumulator-form input is 1 and op is 0 to 3 in class 0, Z is 0 whatever the result. For ops 4 to 7, the accumulator-form input has no effect.
- R7: With class 1 (bit test), Z is the inverse of the operand bit chosen by the index, N is 0 and H is 1. The flag mask is 4'b1110, so C is not written. The result write enable is 0.
- R8: With class 2, the result is the operand with the indexed bit cleared. With class 3, the indexed bit is set. In both classes the result write enable is 1 and the flag mask is 0.
- R9: A flag output whose mask bit is 0 drives 0. In class 1 the result output equals the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 3 | Shift/rotate operation code (0..7) |
| idx_i | input | 3 | Bit index for test, clear and set |
| cls_i | input | 2 | Class: 0 shift/rotate, 1 test, 2 clear, 3 set |
| acc_form_i | input | 1 | Accumulator-only rotate form |
| result_o | output | 8 | Result byte |
| result_we_o | output | 1 | Result write enable |
| flag_z_o | output | 1 | New zero flag |
| flag_n_o | output | 1 | New subtract flag |
| flag_h_o | output | 1 | New half-carry flag |
| flag_c_o | output | 1 | New carry flag |
| flag_we_o | output | 4 | Flag write mask {Z,N,H,C} |

## Verification
The bench targets the edge bits that each operation moves.

- Rotate-left of 0x80 tests wrap-around. A design that dropped the wrap would return 0x00 with Z set.
- Arithmetic right shift of 0x81 tests sign retention. A design that lost the sign bit would return 0x40.
- Rotate-through-carry of zero with carry set tests carry entry. A design that ignored the carry would report zero.
- The accumulator form with a zero result checks that Z stays clear. It also checks that the form does not leak into the plain shifts.
- Bit test on bit 7 checks that C is left unwritten. Clear and set on the end bits check for an off-by-one index or a stray flag write.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    CLS_SHROT = 2'd0,
    CLS_TEST  = 2'd1,
    CLS_CLR   = 2'd2,
    CLS_SET   = 2'd3
  } cls_e;

  typedef enum logic [2:0] {
    OP_RLC  = 3'd0,
    OP_RRC  = 3'd1,
    OP_RL   = 3'd2,
    OP_RR   = 3'd3,
    OP_SLA  = 3'd4,
    OP_SRA  = 3'd5,
    OP_SWAP = 3'd6,
    OP_SRL  = 3'd7
  } op_e;

  localparam int FLG_Z = 3;
  localparam int FLG_N = 2;
  localparam int FLG_H = 1;
  localparam int FLG_C = 0;
endpackage

// File: rtl/bsr_shifter.sv
module bsr_shifter
  import bsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic             cin_i,
  input  op_e              op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam int HALF = WIDTH / 2;

  always_comb begin
    res_o  = opnd_i;
    cout_o = 1'b0;
    unique case (op_i)
      OP_RLC: begin
        res_o  = {opnd_i[WIDTH-2:0], opnd_i[WIDTH-1]};
        cout_o = opnd_i[WIDTH-1];
      end
      OP_RRC: begin
        res_o  = {opnd_i[0], opnd_i[WIDTH-1:1]};
        cout_o = opnd_i[0];
      end
      OP_RL: begin
        res_o  = {opnd_i[WIDTH-2:0], cin_i};
        cout_o = opnd_i[WIDTH-1];
      end
      OP_RR: begin
        res_o  = {cin_i, opnd_i[WIDTH-1:1]};
        cout_o = opnd_i[0];
      end
      OP_SLA: begin
        res_o  = {opnd_i[WIDTH-2:0], 1'b0};
        cout_o = opnd_i[WIDTH-1];
      end
      OP_SRA: begin
        res_o  = {opnd_i[WIDTH-1], opnd_i[WIDTH-1:1]};
        cout_o = opnd_i[0];
      end
      OP_SWAP: begin
        res_o  = {opnd_i[HALF-1:0], opnd_i[WIDTH-1:HALF]};
        cout_o = 1'b0;
      end
      OP_SRL: begin
        res_o  = {1'b0, opnd_i[WIDTH-1:1]};
        cout_o = opnd_i[0];
      end
      default: begin
        res_o  = opnd_i;
        cout_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bsr_bitop.sv
module bsr_bitop #(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             fill_i,
  output logic [WIDTH-1:0] mod_o,
  output logic             picked_o
);
  logic [WIDTH-1:0] sel;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    assign sel[gi]   = (idx_i == IDX_W'(gi));
    assign mod_o[gi] = sel[gi] ? fill_i : opnd_i[gi];
  end

  assign picked_o = |(opnd_i & sel);
endmodule

// File: rtl/bit_shift_rotate_unit.sv
module bit_shift_rotate_unit
  import bsr_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic             carry_i,
  input  logic [2:0]       op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       cls_i,
  input  logic             acc_form_i,
  output logic [WIDTH-1:0] result_o,
  output logic             result_we_o,
  output logic             flag_z_o,
  output logic             flag_n_o,
  output logic             flag_h_o,
  output logic             flag_c_o,
  output logic [3:0]       flag_we_o
);
  cls_e             cls;
  op_e              op;
  logic [WIDTH-1:0] sh_res;
  logic             sh_cout;
  logic [WIDTH-1:0] bit_res;
  logic             bit_val;
  logic             is_rot4;

  assign cls     = cls_e'(cls_i);
  assign op      = op_e'(op_i);
  assign is_rot4 = ~op_i[2];

  bsr_shifter #(.WIDTH(WIDTH)) u_shifter (
    .opnd_i (opnd_i),
    .cin_i  (carry_i),
    .op_i   (op),
    .res_o  (sh_res),
    .cout_o (sh_cout)
  );

  bsr_bitop #(.WIDTH(WIDTH)) u_bitop (
    .opnd_i   (opnd_i),
    .idx_i    (idx_i),
    .fill_i   (cls == CLS_SET),
    .mod_o    (bit_res),
    .picked_o (bit_val)
  );

  always_comb begin
    result_o    = opnd_i;
    result_we_o = 1'b0;
    flag_z_o    = 1'b0;
    flag_n_o    = 1'b0;
    flag_h_o    = 1'b0;
    flag_c_o    = 1'b0;
    flag_we_o   = 4'b0000;
    unique case (cls)
      CLS_SHROT: begin
        result_o    = sh_res;
        result_we_o = 1'b1;
        flag_z_o    = (sh_res == '0) && !(acc_form_i && is_rot4);
        flag_c_o    = sh_cout;
        flag_we_o   = 4'b1111;
      end
      CLS_TEST: begin
        flag_z_o         = ~bit_val;
        flag_h_o         = 1'b1;
        flag_we_o[FLG_Z] = 1'b1;
        flag_we_o[FLG_N] = 1'b1;
        flag_we_o[FLG_H] = 1'b1;
      end
      CLS_CLR, CLS_SET: begin
        result_o    = bit_res;
        result_we_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bit_shift_rotate_unit_checker.sv
module bit_shift_rotate_unit_checker #(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] opnd_i,
  input logic             carry_i,
  input logic [2:0]       op_i,
  input logic [IDX_W-1:0] idx_i,
  input logic [1:0]       cls_i,
  input logic             acc_form_i,
  input logic [WIDTH-1:0] result_o,
  input logic             result_we_o,
  input logic             flag_z_o,
  input logic             flag_n_o,
  input logic             flag_h_o,
  input logic             flag_c_o,
  input logic [3:0]       flag_we_o
);
  always_comb begin
    if (cls_i == 2'd0) begin
      a_r5_shift_writes_all: assert (result_we_o && flag_we_o == 4'b1111 && !flag_n_o && !flag_h_o);
      if (acc_form_i && !op_i[2]) begin
        a_r6_acc_rot_z_clear: assert (!flag_z_o);
      end
      if (op_i == 3'd6) begin
        a_r4_swap_no_carry: assert (!flag_c_o && $countones(result_o) == $countones(opnd_i));
      end
    end
    if (cls_i == 2'd1) begin
      a_r7_test_no_write: assert (!result_we_o && flag_we_o == 4'b1110 && flag_h_o && !flag_n_o);
      a_r9_test_passthru: assert (result_o == opnd_i && !flag_c_o);
    end
    if (cls_i[1]) begin
      a_r8_single_bit: assert (result_we_o && flag_we_o == 4'b0000 && $countones(result_o ^ opnd_i) <= 1);
    end
  end
endmodule

bind bit_shift_rotate_unit bit_shift_rotate_unit_checker #(.WIDTH(WIDTH)) u_chk (
  .opnd_i      (opnd_i),
  .carry_i     (carry_i),
  .op_i        (op_i),
  .idx_i       (idx_i),
  .cls_i       (cls_i),
  .acc_form_i  (acc_form_i),
  .result_o    (result_o),
  .result_we_o (result_we_o),
  .flag_z_o    (flag_z_o),
  .flag_n_o    (flag_n_o),
  .flag_h_o    (flag_h_o),
  .flag_c_o    (flag_c_o),
  .flag_we_o   (flag_we_o)
);

// File: tb/bit_shift_rotate_unit_tb.sv
module bit_shift_rotate_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opnd;
  logic       cin;
  logic [2:0] op;
  logic [2:0] idx;
  logic [1:0] cls;
  logic       acc;
  logic [7:0] res;
  logic       rwe, fz, fn, fh, fc;
  logic [3:0] fwe;
  logic [16:0] cap;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bit_shift_rotate_unit u_dut (
    .opnd_i(opnd), .carry_i(cin), .op_i(op), .idx_i(idx), .cls_i(cls),
    .acc_form_i(acc), .result_o(res), .result_we_o(rwe), .flag_z_o(fz),
    .flag_n_o(fn), .flag_h_o(fh), .flag_c_o(fc), .flag_we_o(fwe)
  );

  // registered wrapper: outputs captured one edge after inputs are applied
  always_ff @(posedge clk) begin
    if (rst) cap <= '0;
    else     cap <= {res, rwe, fz, fn, fh, fc, fwe};
  end

  function automatic logic [16:0] model(logic [7:0] a, logic ci, logic [2:0] o,
                                        logic [2:0] ix, logic [1:0] cl, logic ac);
    logic [7:0] r;
    logic c, z, h, we;
    logic [3:0] m;
    r = a; c = 1'b0; z = 1'b0; h = 1'b0; we = 1'b0; m = 4'h0;
    case (cl)
      2'd0: begin
        case (o)
          3'd0: begin c = a[7]; r = (a << 1) | (a >> 7); end
          3'd1: begin c = a[0]; r = (a >> 1) | (a << 7); end
          3'd2: begin c = a[7]; r = (a << 1) | {7'b0, ci}; end
          3'd3: begin c = a[0]; r = (a >> 1) | {ci, 7'b0}; end
          3'd4: begin c = a[7]; r = a << 1; end
          3'd5: begin c = a[0]; r = (a >> 1) | (a & 8'h80); end
          3'd6: begin c = 1'b0; r = (a << 4) | (a >> 4); end
          default: begin c = a[0]; r = a >> 1; end
        endcase
        z = (r == 8'h00) && !(ac && o < 3'd4);
        we = 1'b1; m = 4'hF;
      end
      2'd1: begin
        z = ((a >> ix) & 8'h01) == 8'h00;
        h = 1'b1; m = 4'hE;
      end
      2'd2: begin r = a & ~(8'h01 << ix); we = 1'b1; end
      default: begin r = a | (8'h01 << ix); we = 1'b1; end
    endcase
    return {r, we, z, 1'b0, h, c, m};
  endfunction

  task automatic run(input logic [7:0] a, input logic ci, input logic [2:0] o,
                     input logic [2:0] ix, input logic [1:0] cl, input logic ac,
                     input string tag);
    logic [16:0] exp;
    @(negedge clk);
    opnd = a; cin = ci; op = o; idx = ix; cls = cl; acc = ac;
    exp = model(a, ci, o, ix, cl, ac);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (cap !== exp) begin
      errors++;
      $display("FAIL %s: a=%h c=%b op=%0d idx=%0d cls=%0d acc=%b actual=%h expected=%h",
               tag, a, ci, o, ix, cl, ac, cap, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    opnd = 8'h00; cin = 1'b0; op = 3'd0; idx = 3'd0; cls = 2'd0; acc = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (cap !== 17'h0) begin
      errors++;
      $display("FAIL reset: actual=%h expected=%h", cap, 17'h0);
    end
    rst = 1'b0;
    run(8'h80, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, "R1 rlc wrap");
    run(8'h01, 1'b0, 3'd1, 3'd0, 2'd0, 1'b0, "R1 rrc wrap");
    run(8'h00, 1'b1, 3'd3, 3'd0, 2'd0, 1'b0, "R2 rr carry in");
    run(8'h80, 1'b0, 3'd2, 3'd0, 2'd0, 1'b0, "R2 rl to zero");
    run(8'h81, 1'b0, 3'd5, 3'd0, 2'd0, 1'b0, "R3 sra sign");
    run(8'h01, 1'b1, 3'd7, 3'd0, 2'd0, 1'b0, "R3 srl zero");
    run(8'h80, 1'b0, 3'd4, 3'd0, 2'd0, 1'b0, "R3 sla zero");
    run(8'hF0, 1'b1, 3'd6, 3'd0, 2'd0, 1'b0, "R4 swap");
    run(8'h00, 1'b0, 3'd6, 3'd0, 2'd0, 1'b0, "R5 swap zero");
    run(8'h80, 1'b0, 3'd2, 3'd0, 2'd0, 1'b1, "R6 acc rl zero");
    run(8'h00, 1'b0, 3'd0, 3'd0, 2'd0, 1'b1, "R6 acc rlc zero");
    run(8'h80, 1'b0, 3'd4, 3'd0, 2'd0, 1'b1, "R6 acc no effect sla");
    run(8'h7F, 1'b1, 3'd0, 3'd7, 2'd1, 1'b0, "R7 test bit7 zero");
    run(8'h01, 1'b1, 3'd0, 3'd0, 2'd1, 1'b0, "R9 test passthru");
    run(8'hFF, 1'b1, 3'd0, 3'd0, 2'd2, 1'b0, "R8 clear bit0");
    run(8'h00, 1'b1, 3'd0, 3'd7, 2'd3, 1'b0, "R8 set bit7");
    for (int i = 0; i < 400; i++) begin
      logic [1:0] cl;
      cl = 2'($urandom);
      run(8'($urandom), 1'($urandom), 3'($urandom), 3'($urandom), cl, 1'($urandom),
          cl == 2'd0 ? "R1 R2 R3 R5 random" : cl == 2'd1 ? "R7 random" : "R8 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule